// File: doc/BRIEF.md
# Dual Option-ROM Window Decoder

This block decodes the memory half of a 20-bit expansion bus for two independent option ROMs. Each ROM sits in the top 256 KB of the address space, inside a window chosen by its own 5-bit base selector. Window n begins at 0xC0000 + n × 0x2000, so the 32 windows run up to 0xFE000–0xFFFFF. A per-ROM size input picks a small device (8 KB, 64 Kbit) or a large one (32 KB, 256 Kbit). For each ROM the block drives a chip enable, a read strobe, a write strobe and the offset into the device. An activity indicator stays lit for a short while after each access.

Decoding of a ROM happens only while its enable input is set and the bus address-enable line (`aen`, high while a DMA controller owns the bus) is low. A write reaches a device only while that ROM's write-enable input is set, so a writable part can be programmed in its socket and is otherwise safe from stray writes. If a misconfiguration makes both windows cover the same address, ROM 0 takes the cycle and a clash flag is raised. All strobes are active high.

Top module: `optrom_decode`

## Requirements
- R1: In small mode a ROM's chip enable is high exactly when busAddr[19:18] are both 1 and busAddr[17:13] equal that ROM's 5-bit base selector (ROM k uses romBase[5k+4:5k]), subject to R4 and R8.
- R2: In large mode (romBig[k]=1) only busAddr[17:15] are compared with base selector bits [4:2]. Selector bits [1:0] have no effect, and the offset is busAddr[14:0].
- R3: In small mode the 15-bit offset of ROM k (romOfs[15k+14:15k]) carries busAddr[12:0] with its two upper bits zero.
- R4: While aen is 1, or while romEn[k] is 0, ROM k's chip enable, read strobe and write strobe are all low.
- R5: romOe[k] is high exactly when romCe[k] and memRd are both high.
- R6: romWe[k] is high only when romCe[k], memWr and romWrEn[k] are all high. With romWrEn[k] low, a write to the window leaves romWe[k] low and romOe[k] low.
- R7: The two ROMs decode independently. An access inside ROM 1's window alone raises only ROM 1's strobes.
- R8: When both windows match one address, romCe[0] is high, romCe[1] is low, and winClash is high. Otherwise winClash is low.
- R9: romAct[k] goes high at the first clock edge that sees an access (chip enable with memRd or memWr). It stays high until ACT_HOLD (default 4) edges have passed with no access, then it falls.
- R10: After reset both activity indicators are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the activity stretchers |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 20 | Bus memory address |
| aen | input | 1 | High while a DMA controller owns the bus; blocks decoding |
| memRd | input | 1 | Memory read strobe, active high |
| memWr | input | 1 | Memory write strobe, active high |
| romEn | input | 2 | Per-ROM decode enable |
| romWrEn | input | 2 | Per-ROM write permission |
| romBase | input | 10 | Per-ROM 5-bit base selector, ROM k at bits [5k+4:5k] |
| romBig | input | 2 | Per-ROM size: 0 = 8 KB, 1 = 32 KB |
| romCe | output | 2 | Per-ROM chip enable |
| romOe | output | 2 | Per-ROM output enable |
| romWe | output | 2 | Per-ROM write strobe |
| romOfs | output | 30 | Per-ROM 15-bit in-window offset, ROM k at bits [15k+14:15k] |
| romAct | output | 2 | Per-ROM activity indicator |
| winClash | output | 1 | Both windows matched the same address |

## Verification
The hardest case to reach is the overlap of the two windows. It never arises under a sane setup, and it only shows itself in the priority between the chip enables. The stimulus forces it by giving both ROMs the same base, and also by putting ROM 0 in large mode over a small ROM 1 window that it contains. Both cases must give ROM 0 the cycle. The other delicate case is the tail of the activity stretcher. The bench drives an access and then counts idle cycles one by one. It checks that the indicator is still high one cycle before the hold expires and low on the cycle it expires.

// File: rtl/optrom_pkg.sv
package optrom_pkg;

  // Strobe bundle handed from the control to the top for one ROM.
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
  } romStrobe_t;

endpackage

// File: rtl/optrom_window.sv
// Datapath: address comparison and offset extraction for one ROM window.
module optrom_window #(
  parameter int ADDR_W   = 20,
  parameter int SEL_W    = 5,
  parameter int WIN_LOG2 = 13,
  parameter int BIG_LOG2 = 15
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                decodeOn,
  input  logic [SEL_W-1:0]    baseSel,
  input  logic                bigMode,
  output logic                hit,
  output logic [BIG_LOG2-1:0] offset
);
  localparam int SEL_HI = WIN_LOG2 + SEL_W - 1;
  localparam int DROP   = BIG_LOG2 - WIN_LOG2;

  logic upperOk;
  logic smallOk;
  logic bigOk;

  always_comb begin
    upperOk = &addr[ADDR_W-1:SEL_HI+1];
    smallOk = (addr[SEL_HI:WIN_LOG2] == baseSel);
    bigOk   = (addr[SEL_HI:BIG_LOG2] == baseSel[SEL_W-1:DROP]);
    hit     = decodeOn & upperOk & (bigMode ? bigOk : smallOk);
    offset  = bigMode ? addr[BIG_LOG2-1:0]
                      : {{DROP{1'b0}}, addr[WIN_LOG2-1:0]};
  end
endmodule

// File: rtl/optrom_ctrl.sv
// Control: priority between windows, strobe qualification, activity hold.
module optrom_ctrl
  import optrom_pkg::*;
#(
  parameter int NROM     = 2,
  parameter int ACT_HOLD = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NROM-1:0] rawHit,
  input  logic            memRd,
  input  logic            memWr,
  input  logic [NROM-1:0] wrEn,
  output romStrobe_t      strb [NROM],
  output logic [NROM-1:0] act,
  output logic            clash
);
  localparam int CNT_W = $clog2(ACT_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(ACT_HOLD);

  logic [NROM-1:0] grant;
  logic            taken;

  // Lowest index wins; a hit seen after an earlier one marks a clash.
  always_comb begin
    taken = 1'b0;
    clash = 1'b0;
    grant = '0;
    for (int k = 0; k < NROM; k++) begin
      grant[k] = rawHit[k] & ~taken;
      clash    = clash | (rawHit[k] & taken);
      taken    = taken | rawHit[k];
    end
  end

  for (genvar k = 0; k < NROM; k++) begin : g_rom
    logic [CNT_W-1:0] holdCnt;
    logic             busy;

    always_comb begin
      strb[k].ce = grant[k];
      strb[k].oe = grant[k] & memRd;
      strb[k].we = grant[k] & memWr & wrEn[k];
      busy       = grant[k] & (memRd | memWr);
      act[k]     = (holdCnt != '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN)               holdCnt <= '0;
      else if (busy)           holdCnt <= HOLD_LD;
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/optrom_decode.sv
// Top: two option-ROM window decoders sharing one bus.
module optrom_decode
  import optrom_pkg::*;
#(
  parameter int NROM     = 2,
  parameter int ADDR_W   = 20,
  parameter int SEL_W    = 5,
  parameter int WIN_LOG2 = 13,
  parameter int BIG_LOG2 = 15,
  parameter int ACT_HOLD = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     aen,
  input  logic                     memRd,
  input  logic                     memWr,
  input  logic [NROM-1:0]          romEn,
  input  logic [NROM-1:0]          romWrEn,
  input  logic [NROM*SEL_W-1:0]    romBase,
  input  logic [NROM-1:0]          romBig,
  output logic [NROM-1:0]          romCe,
  output logic [NROM-1:0]          romOe,
  output logic [NROM-1:0]          romWe,
  output logic [NROM*BIG_LOG2-1:0] romOfs,
  output logic [NROM-1:0]          romAct,
  output logic                     winClash
);
  logic [NROM-1:0] rawHit;
  romStrobe_t      strb [NROM];

  for (genvar k = 0; k < NROM; k++) begin : g_win
    logic decodeOn;
    assign decodeOn = romEn[k] & ~aen;

    optrom_window #(
      .ADDR_W  (ADDR_W),
      .SEL_W   (SEL_W),
      .WIN_LOG2(WIN_LOG2),
      .BIG_LOG2(BIG_LOG2)
    ) u_win (
      .addr    (busAddr),
      .decodeOn(decodeOn),
      .baseSel (romBase[k*SEL_W +: SEL_W]),
      .bigMode (romBig[k]),
      .hit     (rawHit[k]),
      .offset  (romOfs[k*BIG_LOG2 +: BIG_LOG2])
    );

    assign romCe[k] = strb[k].ce;
    assign romOe[k] = strb[k].oe;
    assign romWe[k] = strb[k].we;
  end

  optrom_ctrl #(
    .NROM    (NROM),
    .ACT_HOLD(ACT_HOLD)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rawHit(rawHit),
    .memRd (memRd),
    .memWr (memWr),
    .wrEn  (romWrEn),
    .strb  (strb),
    .act   (romAct),
    .clash (winClash)
  );
endmodule

// File: rtl/optrom_decode_chk.sv
module optrom_decode_chk #(
  parameter int NROM     = 2,
  parameter int ADDR_W   = 20,
  parameter int SEL_W    = 5,
  parameter int WIN_LOG2 = 13,
  parameter int BIG_LOG2 = 15
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     aen,
  input logic                     memRd,
  input logic                     memWr,
  input logic [NROM-1:0]          romEn,
  input logic [NROM-1:0]          romWrEn,
  input logic [NROM-1:0]          romCe,
  input logic [NROM-1:0]          romOe,
  input logic [NROM-1:0]          romWe,
  input logic [NROM-1:0]          romAct,
  input logic                     winClash
);
  localparam int UP_LO = WIN_LOG2 + SEL_W;

  p_one_ce_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(romCe));

  p_clash_prio_r8: assert property (@(posedge clk) disable iff (!rstN)
    winClash |-> (romCe[0] && !romCe[1]));

  for (genvar k = 0; k < NROM; k++) begin : g_k
    p_upper_r1: assert property (@(posedge clk) disable iff (!rstN)
      romCe[k] |-> (&busAddr[ADDR_W-1:UP_LO]));

    p_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
      (aen || !romEn[k]) |-> !(romCe[k] || romOe[k] || romWe[k]));

    p_oe_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
      romOe[k] |-> (romCe[k] && memRd));

    p_we_guard_r6: assert property (@(posedge clk) disable iff (!rstN)
      romWe[k] |-> (romCe[k] && memWr && romWrEn[k]));

    p_act_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
      (romCe[k] && (memRd || memWr)) |=> romAct[k]);
  end
endmodule

bind optrom_decode optrom_decode_chk #(
  .NROM(NROM), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
  .WIN_LOG2(WIN_LOG2), .BIG_LOG2(BIG_LOG2)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .aen(aen),
  .memRd(memRd), .memWr(memWr), .romEn(romEn), .romWrEn(romWrEn),
  .romCe(romCe), .romOe(romOe), .romWe(romWe), .romAct(romAct),
  .winClash(winClash)
);

// File: tb/optrom_decode_tb.sv
module optrom_decode_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        aen = 1'b0;
  logic        memRd = 1'b0;
  logic        memWr = 1'b0;
  logic [1:0]  romEn = '0;
  logic [1:0]  romWrEn = '0;
  logic [9:0]  romBase = '0;
  logic [1:0]  romBig = '0;
  logic [1:0]  romCe, romOe, romWe, romAct;
  logic [29:0] romOfs;
  logic        winClash;

  always #2.5 clk = ~clk;

  optrom_decode u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .aen(aen), .memRd(memRd),
    .memWr(memWr), .romEn(romEn), .romWrEn(romWrEn), .romBase(romBase),
    .romBig(romBig), .romCe(romCe), .romOe(romOe), .romWe(romWe),
    .romOfs(romOfs), .romAct(romAct), .winClash(winClash)
  );

  typedef struct {
    logic [1:0]  ce, oe, we, act;
    logic [29:0] ofs;
    logic        clash;
    logic        chkAct;
    int          req;
  } expItem_t;

  expItem_t scoreQ[$];
  event     pushEv;
  int       nCmp = 0;
  int       nBad = 0;
  int       cyc = 0;
  bit       done = 0;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // Expected outputs derived from R1..R8.
  function automatic expItem_t model(int req, logic chkAct, logic [1:0] actExp);
    expItem_t e;
    logic [1:0] raw;
    logic [4:0] sel;
    for (int k = 0; k < 2; k++) begin
      sel = romBase[k*5 +: 5];
      raw[k] = romEn[k] && !aen && (busAddr[19:18] == 2'b11) &&
               (romBig[k] ? (busAddr[17:15] == sel[4:2]) : (busAddr[17:13] == sel));
      e.ofs[k*15 +: 15] = romBig[k] ? busAddr[14:0] : {2'b00, busAddr[12:0]};
    end
    e.ce    = {raw[1] & ~raw[0], raw[0]};
    e.clash = raw[0] & raw[1];
    e.oe    = e.ce & {2{memRd}};
    e.we    = e.ce & {2{memWr}} & romWrEn;
    e.act   = actExp;
    e.chkAct = chkAct;
    e.req   = req;
    return e;
  endfunction

  task automatic apply(logic [19:0] a, logic ae, logic rd, logic wr,
                       logic [1:0] en, logic [1:0] wen, logic [4:0] b0,
                       logic [4:0] b1, logic [1:0] big, int req,
                       logic chkAct, logic [1:0] actExp);
    @(negedge clk);
    busAddr = a; aen = ae; memRd = rd; memWr = wr;
    romEn = en; romWrEn = wen; romBase = {b1, b0}; romBig = big;
    #1;
    scoreQ.push_back(model(req, chkAct, actExp));
    -> pushEv;
  endtask

  task automatic idle(int req, logic chkAct, logic [1:0] actExp);
    apply(20'h00000, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 5'd0, 5'd1, 2'b00,
          req, chkAct, actExp);
  endtask

  task automatic cmp(string what, int req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares with the live outputs.
  initial begin
    forever begin
      @(pushEv);
      while (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        cmp("ce", e.req, 32'(romCe), 32'(e.ce));
        cmp("oe", e.req, 32'(romOe), 32'(e.oe));
        cmp("we", e.req, 32'(romWe), 32'(e.we));
        cmp("ofs", e.req, 32'(romOfs), 32'(e.ofs));
        cmp("clash", e.req, 32'(winClash), 32'(e.clash));
        if (e.chkAct) cmp("act", e.req, 32'(romAct), 32'(e.act));
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R10: indicators low coming out of reset
    idle(10, 1'b1, 2'b00);
    @(negedge clk); rstN = 1'b1;
    idle(10, 1'b1, 2'b00);

    // R1: every start address, both ROMs, small mode
    for (int n = 0; n < 32; n++) begin
      apply(20'hC0000 + 20'(n) * 20'h2000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00,
            5'(n), 5'(31 - n), 2'b00, 1, 1'b0, 2'b00);
      apply(20'hC1FFF + 20'(n) * 20'h2000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00,
            5'(31 - n), 5'(n), 2'b00, 1, 1'b0, 2'b00);
    end
    // R1: neighbouring window misses, A18 low misses
    apply(20'hCC000, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 1, 1'b0, 2'b00);
    apply(20'h8A123, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 1, 1'b0, 2'b00);
    apply(20'h4A123, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 1, 1'b0, 2'b00);
    // R3: small-mode offset
    apply(20'hCA123, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 3, 1'b0, 2'b00);
    apply(20'hEDABC, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'h16, 5'd0, 2'b00, 3, 1'b0, 2'b00);
    // R2: large mode, low selector bits ignored, wide offset
    for (int lo = 0; lo < 4; lo++)
      apply(20'hEDABC, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, {3'b101, 2'(lo)}, 5'd0,
            2'b01, 2, 1'b0, 2'b00);
    apply(20'hF0000, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'h14, 5'd0, 2'b01, 2, 1'b0, 2'b00);
    apply(20'hE7FFF, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 5'h14, 5'd0, 2'b01, 2, 1'b0, 2'b00);
    apply(20'hE8000, 1'b0, 1'b1, 1'b0, 2'b10, 2'b00, 5'd0, 5'h17, 2'b10, 2, 1'b0, 2'b00);
    // R4: aen high, enable low
    apply(20'hCA123, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11, 5'd5, 5'd5, 2'b00, 4, 1'b0, 2'b00);
    apply(20'hCA123, 1'b0, 1'b1, 1'b1, 2'b00, 2'b11, 5'd5, 5'd5, 2'b00, 4, 1'b0, 2'b00);
    apply(20'hCA123, 1'b1, 1'b0, 1'b1, 2'b10, 2'b11, 5'd0, 5'd5, 2'b00, 4, 1'b0, 2'b00);
    // R5: no read strobe -> no output enable
    apply(20'hCA123, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 5, 1'b0, 2'b00);
    // R6: write with protection on, then off
    apply(20'hCA123, 1'b0, 1'b0, 1'b1, 2'b01, 2'b00, 5'd5, 5'd0, 2'b00, 6, 1'b0, 2'b00);
    apply(20'hCA123, 1'b0, 1'b0, 1'b1, 2'b01, 2'b01, 5'd5, 5'd0, 2'b00, 6, 1'b0, 2'b00);
    apply(20'hD2000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b01, 5'd5, 5'd9, 2'b00, 6, 1'b0, 2'b00);
    // R7: ROM 1 alone, ROM 0 configured elsewhere
    apply(20'hD2000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b10, 5'd5, 5'd9, 2'b00, 7, 1'b0, 2'b00);
    apply(20'hD2000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b10, 5'd5, 5'd9, 2'b00, 7, 1'b0, 2'b00);
    // R8: overlap, same base and large-over-small
    apply(20'hCA123, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 5'd5, 5'd5, 2'b00, 8, 1'b0, 2'b00);
    apply(20'hE9000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, 5'h14, 5'h14, 2'b01, 8, 1'b0, 2'b00);
    apply(20'hE9000, 1'b0, 1'b1, 1'b0, 2'b10, 2'b00, 5'h14, 5'h14, 2'b01, 8, 1'b0, 2'b00);

    // R9: activity stretch with ACT_HOLD = 4
    repeat (6) idle(9, 1'b0, 2'b00);
    idle(9, 1'b1, 2'b00);
    apply(20'hCA000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 5'd5, 5'd9, 2'b00, 9, 1'b0, 2'b00);
    apply(20'hCA000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 5'd5, 5'd9, 2'b00, 9, 1'b1, 2'b01);
    idle(9, 1'b1, 2'b01);
    idle(9, 1'b1, 2'b01);
    idle(9, 1'b1, 2'b01);
    idle(9, 1'b1, 2'b01);
    idle(9, 1'b1, 2'b00);
    // R9: a protected write is still an access; aen-blocked cycle is not
    apply(20'hD2000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 5'd5, 5'd9, 2'b00, 9, 1'b0, 2'b00);
    apply(20'hD2000, 1'b1, 1'b0, 1'b1, 2'b11, 2'b00, 5'd5, 5'd9, 2'b00, 9, 1'b1, 2'b10);
    repeat (4) idle(9, 1'b0, 2'b00);
    idle(9, 1'b1, 2'b00);
    apply(20'hD2000, 1'b1, 1'b1, 1'b0, 2'b11, 2'b00, 5'd5, 5'd9, 2'b00, 4, 1'b0, 2'b00);
    idle(4, 1'b1, 2'b00);

    #2;
    done = 1;
    report();
    $finish;
  end
endmodule